// File: doc/BRIEF.md
# Bus Acknowledge and Phase-Sync Controller

This block answers 68000-style bus cycles that a master runs across a buffered backplane. It drives the active-low data-transfer acknowledge on behalf of the addressed slave. It also rebuilds the processor-rate clock from two quadrature clock phases that are half that rate. The slave never drives acknowledge. It can only hold the cycle off by pulling its ready line low. Acknowledge then follows once the normal cycle length has elapsed.

Cycles that target the display memory region (the lowest half megabyte of the address space) must line up with the slower quadrature clock. The block notes which quadrant of that clock the cycle started in. A cycle that starts with both phase inputs high is out of step, and it gets exactly one extra processor clock of wait before acknowledge. A cycle that starts with both phase inputs low gets the normal timing. While a graphics contention input is high, acknowledge to display memory is held back further. That input has no effect on other addresses.

The block runs on a sampling clock at four times the quadrature rate, one period per quadrant. Every state change happens on a rising edge of the derived processor clock, seen as a one-cycle enable.

Top module: `bus_ack_sync`

## Requirements
- R1: `pclk` equals the XNOR of `c1_n` and `c3_n` at all times. A derived-clock rising edge is a `clk` edge where `pclk` is 1 and it was 0 on the previous `clk` edge.
- R2: `as_n` passes through a SYNC_STAGES-deep synchronizer that advances only on derived-clock rising edges. A cycle starts at the first such edge where the synchronized strobe is low. `dtack_n` changes only on derived-clock rising edges.
- R3: For an address with any bit at or above bit DISP_LOG2 set (19 by default), `dtack_n` goes low on the ACK_DELAY-th derived-clock edge after the start edge (2 by default).
- R4: For a display address (all bits from DISP_LOG2 up are zero), when `c1_n` = `c3_n` = 0 on the start edge, acknowledge has the same timing as R3.
- R5: For a display address, when `c1_n` = `c3_n` = 1 on the start edge, acknowledge comes SYNC_WAIT derived-clock edges later than in R3 (1 by default).
- R6: While `contend` is high, acknowledge of a display-address cycle is held off. For other addresses `contend` has no effect on acknowledge timing.
- R7: While `slave_rdy` is low, acknowledge is held off for any address.
- R8: Once low, `dtack_n` stays low until a derived-clock edge sees the synchronized strobe high. It goes high on that same edge.
- R9: During reset, `dtack_n` is high and the cycle logic is idle. `rst_n` is active low.
- R10: If the strobe is released before the acknowledge conditions are met, the cycle is dropped and `dtack_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, one period per quadrant |
| rst_n | input | 1 | Active-low synchronous reset |
| c1_n | input | 1 | Half-rate clock phase one, active-low form |
| c3_n | input | 1 | Half-rate clock phase two, in quadrature with phase one |
| as_n | input | 1 | Address strobe from the bus master, active low |
| addr | input | ADDR_W | Cycle address |
| slave_rdy | input | 1 | Slave ready; low holds acknowledge off |
| contend | input | 1 | Graphics contention; high delays display acknowledge |
| pclk | output | 1 | Derived processor-rate clock |
| dtack_n | output | 1 | Data-transfer acknowledge, active low |

## Verification
Two mechanisms can decide the same derived-clock edge: the expiry of the out-of-step wait state, and the end of a slave ready hold. The bench provokes this by starting an out-of-step display cycle and releasing `slave_rdy` once just before that edge and once just after it. It expects acknowledge to be seen 11 and 13 sampling cycles after the strobe falls. A behavioural model runs on every clock and judges the same overlap for contention holds that end inside the wait window.

// File: rtl/bus_ack_pkg.sv
package bus_ack_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACK  = 2'd2
   } ack_state_t;
endpackage

// File: rtl/pclk_gen.sv
module pclk_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic c1_n,
   input  logic c3_n,
   output logic pclk,
   output logic tick
);
   logic pclk_d;

   // Processor-rate clock rebuilt from the quadrature phases
   assign pclk = ~(c1_n ^ c3_n);

   always_ff @(posedge clk) begin
      if (!rst_n) pclk_d <= 1'b0;
      else        pclk_d <= pclk;
   end

   assign tick = pclk & ~pclk_d;
endmodule

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic as_n,
   output logic as_sync_n
);
   logic [STAGES-1:0] chain;
   logic [STAGES-1:0] chain_d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign chain_d[i] = as_n;
      end else begin : g_body
         assign chain_d[i] = chain[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  chain <= '1;
      else if (en) chain <= chain_d;
   end

   assign as_sync_n = chain[STAGES-1];

   // R2
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(as_sync_n));
endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
   import bus_ack_pkg::*;
#(
   parameter int ACK_DELAY = 2,
   parameter int SYNC_WAIT = 1,
   parameter int CNT_W     = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic as_sync_n,
   input  logic phase_hi,
   input  logic in_disp,
   input  logic slave_rdy,
   input  logic contend,
   output logic dtack_n
);
   ack_state_t       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] target;
   logic             oos_q;
   logic             disp_q;
   logic             release_ok;

   assign target     = CNT_W'(ACK_DELAY) + ((oos_q & disp_q) ? CNT_W'(SYNC_WAIT) : '0);
   assign release_ok = slave_rdy & ~(disp_q & contend);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         oos_q  <= 1'b0;
         disp_q <= 1'b0;
      end else if (tick) begin
         case (state)
            ST_IDLE: if (!as_sync_n) begin
               oos_q  <= phase_hi;
               disp_q <= in_disp;
               cnt    <= CNT_W'(1);
               state  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (as_sync_n) state <= ST_IDLE;
               else begin
                  if (cnt >= target && release_ok) state <= ST_ACK;
                  if (cnt != '1) cnt <= cnt + CNT_W'(1);
               end
            end
            ST_ACK: if (as_sync_n) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign dtack_n = (state != ST_ACK);

   // R8
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && as_sync_n && state == ST_ACK) |=> dtack_n);
   // R7
   rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !slave_rdy && state == ST_WAIT) |=> dtack_n);
   // R6
   contend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && contend && disp_q && state == ST_WAIT) |=> dtack_n);
   // R3
   min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state == ST_WAIT && cnt < CNT_W'(ACK_DELAY)) |=> dtack_n);
   // R2
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(dtack_n));
endmodule

// File: rtl/bus_ack_sync.sv
module bus_ack_sync #(
   parameter int ADDR_W      = 24,
   parameter int DISP_LOG2   = 19,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_DELAY   = 2,
   parameter int SYNC_WAIT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              c1_n,
   input  logic              c3_n,
   input  logic              as_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              slave_rdy,
   input  logic              contend,
   output logic              pclk,
   output logic              dtack_n
);
   localparam int CNT_W = $clog2(ACK_DELAY + SYNC_WAIT + 1) + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ACK_DELAY < 1) begin : g_bad_delay
      $error("ACK_DELAY must be at least 1");
   end
   if (DISP_LOG2 >= ADDR_W) begin : g_bad_disp
      $error("DISP_LOG2 must be below ADDR_W");
   end

   logic tick;
   logic as_sync_n;
   logic in_disp;

   assign in_disp = ((addr >> DISP_LOG2) == '0);

   pclk_gen u_pclk (
      .clk   (clk),
      .rst_n (rst_n),
      .c1_n  (c1_n),
      .c3_n  (c3_n),
      .pclk  (pclk),
      .tick  (tick)
   );

   strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tick),
      .as_n      (as_n),
      .as_sync_n (as_sync_n)
   );

   ack_fsm #(
      .ACK_DELAY (ACK_DELAY),
      .SYNC_WAIT (SYNC_WAIT),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .as_sync_n (as_sync_n),
      .phase_hi  (c1_n),
      .in_disp   (in_disp),
      .slave_rdy (slave_rdy),
      .contend   (contend),
      .dtack_n   (dtack_n)
   );
endmodule

// File: tb/bus_ack_sync_tb.sv
module bus_ack_sync_tb;
   localparam int DISP_LIMIT = 1 << 19;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  q = 2'd3;
   logic        c1_n, c3_n;
   logic        as_n = 1'b1;
   logic [23:0] addr = 24'h0;
   logic        slave_rdy = 1'b1;
   logic        contend = 1'b0;
   logic        pclk, dtack_n;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   string cur_req = "R9";

   always #5 clk = ~clk;

   // quadrant sequence (c1_n,c3_n): 11, 10, 00, 01
   assign c1_n = (q < 2);
   assign c3_n = (q == 0) || (q == 3);
   always @(negedge clk) q <= q + 2'd1;

   bus_ack_sync u_dut (
      .clk(clk), .rst_n(rst_n), .c1_n(c1_n), .c3_n(c3_n), .as_n(as_n),
      .addr(addr), .slave_rdy(slave_rdy), .contend(contend),
      .pclk(pclk), .dtack_n(dtack_n)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_pd, m_s1, m_s2, m_oos, m_disp, exp_dn;
   int m_st, m_cnt;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pd = 0; m_s1 = 1; m_s2 = 1; m_st = 0; m_cnt = 0; exp_dn = 1;
      end else begin
         bit p, tk, seen;
         p = (c1_n == c3_n);
         tk = p && !m_pd;
         m_pd = p;
         if (tk) begin
            seen = m_s2; m_s2 = m_s1; m_s1 = as_n;
            if (m_st == 0) begin
               if (!seen) begin
                  m_oos = c1_n; m_disp = (addr < DISP_LIMIT); m_cnt = 1; m_st = 1;
               end
            end else if (m_st == 1) begin
               if (seen) m_st = 0;
               else begin
                  if (m_cnt >= 2 + ((m_oos && m_disp) ? 1 : 0) && slave_rdy && !(m_disp && contend))
                     m_st = 2;
                  m_cnt++;
               end
            end else if (seen) m_st = 0;
         end
         exp_dn = (m_st != 2);
      end
   end

   always @(negedge clk) begin
      #3;
      if (rst_n && !done) begin
         chk(pclk == (c1_n == c3_n), "R1", pclk, c1_n == c3_n);
         chk(dtack_n == exp_dn, cur_req, dtack_n, exp_dn);
      end
   end

   task automatic bus_cycle(input logic [23:0] a, input logic [1:0] ph, input int rdy_lo,
                            input int cont_hi, output int lat);
      forever begin
         @(negedge clk); #1;
         if (q == ph) break;
      end
      addr = a; as_n = 1'b0;
      slave_rdy = (rdy_lo == 0);
      contend = (cont_hi > 0);
      lat = 0;
      while (lat < 60) begin
         @(negedge clk); #1;
         lat++;
         if (lat == rdy_lo) slave_rdy = 1'b1;
         if (lat == cont_hi) contend = 1'b0;
         #1;
         if (!dtack_n) break;
      end
      slave_rdy = 1'b1; contend = 1'b0;
      @(negedge clk); #1;
      as_n = 1'b1;
      begin
         int rel = 0;
         while (rel < 20 && !dtack_n) begin
            @(negedge clk); #2;
            rel++;
         end
         // R8: release seen within the synchronizer delay
         chk(rel <= 7 && dtack_n, "R8", rel, 7);
      end
      repeat (6) @(negedge clk);
   endtask

   initial begin
      int lat, lat_b;
      repeat (3) @(negedge clk);
      #2;
      chk(dtack_n == 1'b1, "R9", dtack_n, 1);
      @(negedge clk); #1;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(dtack_n == 1'b1, "R9", dtack_n, 1);

      // R3: outside display memory, both phases
      cur_req = "R3";
      bus_cycle(24'h080000, 2'd0, 0, 0, lat);
      chk(lat == 9, "R3", lat, 9);
      bus_cycle(24'hF00010, 2'd2, 0, 0, lat_b);
      chk(lat_b == 9, "R3", lat_b, 9);

      // R4: display memory, start with both phase inputs low
      cur_req = "R4";
      bus_cycle(24'h000100, 2'd2, 0, 0, lat);
      chk(lat == 9, "R4", lat, 9);
      chk(lat == lat_b, "R4", lat, lat_b);

      // R5: display memory, start with both phase inputs high
      cur_req = "R5";
      bus_cycle(24'h07FFFE, 2'd0, 0, 0, lat);
      chk(lat == 11, "R5", lat, 11);

      // R6: contention on display memory, then ignored outside it
      cur_req = "R6";
      bus_cycle(24'h000040, 2'd2, 0, 14, lat);
      chk(lat > 14, "R6", lat, 15);
      bus_cycle(24'h100000, 2'd2, 0, 30, lat);
      chk(lat == 9, "R6", lat, 9);
      bus_cycle(24'h000040, 2'd0, 0, 10, lat);
      chk(lat == 11, "R6", lat, 11);

      // R7: ready hold, any region
      cur_req = "R7";
      bus_cycle(24'h200000, 2'd0, 14, 0, lat);
      chk(lat > 14, "R7", lat, 15);
      bus_cycle(24'h000000, 2'd2, 16, 0, lat);
      chk(lat > 16, "R7", lat, 17);

      // R5 with R7 on the same edge as the wait-state expiry
      cur_req = "R5";
      bus_cycle(24'h001000, 2'd0, 10, 0, lat);
      chk(lat == 11, "R5/R7", lat, 11);
      bus_cycle(24'h001000, 2'd0, 11, 0, lat);
      chk(lat == 13, "R5/R7", lat, 13);

      // R10: strobe dropped before acknowledge
      cur_req = "R10";
      forever begin
         @(negedge clk); #1;
         if (q == 2'd0) break;
      end
      addr = 24'h000200; as_n = 1'b0;
      @(negedge clk); #1;
      as_n = 1'b1;
      begin
         bit seen_ack = 0;
         repeat (20) begin
            @(negedge clk); #2;
            if (!dtack_n) seen_ack = 1;
         end
         chk(!seen_ack, "R10", seen_ack, 0);
      end

      // R9: reset mid-cycle drops acknowledge
      cur_req = "R9";
      as_n = 1'b0; addr = 24'h300000;
      repeat (14) @(negedge clk);
      #2;
      chk(dtack_n == 1'b0, "R3", dtack_n, 0);
      #1; rst_n = 1'b0;
      @(negedge clk); #2;
      chk(dtack_n == 1'b1, "R9", dtack_n, 1);
      as_n = 1'b1;

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule